// File: doc/BRIEF.md
# Fractional Sampling-Rate Divider

This block turns a fast reference clock into the sampling-rate enable that a UART transmitter and receiver use. The divisor has a 16-bit integer part, held as a low byte and a high byte, and a 4-bit fraction in sixteenths. An optional divide-by-4 prescaler sits in front of the divider. A two-bit mode field chooses 16, 8 or 4 samples per bit. The block issues a one-cycle sampling tick and a one-cycle bit-time tick that marks every N-th sampling tick.

The fraction is spread over the sampling periods by a 4-bit phase accumulator. Each sampling period adds the fraction to the accumulator. A period whose addition carries out lasts one prescaled clock longer than the integer divisor, so every run of 16 periods spans exactly 16 times the integer plus the fraction. The divisor bytes and the prescaler bit are presented as register values. A load strobe copies the bytes in and restarts the divider from a known phase.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, with no load, the divisor is 1, the fraction 0 and the mode 16X. With the prescaler bit at 0, a sampling tick occurs on every clock and a bit tick on every 16th clock.
- R2: The integer divisor is {high byte, low byte}. With fraction 0 and the prescaler bit at 0, sampling ticks are exactly that many clocks apart.
- R3: An integer divisor of 0 behaves as a divisor of 1.
- R4: The fraction F is field bits [3:0]. Number the sampling periods k = 0, 1, ... from a restart. Period k lasts D+1 prescaled clocks when ((k·F mod 16) + F) ≥ 16 and D clocks otherwise, so 16 periods take 16·D + F.
- R5: With the prescaler bit at 1, each prescaled clock is 4 reference clocks, so every period length is multiplied by 4. With the bit at 0 the factor is 1.
- R6: Field bits [5:4] select the mode: 00 is 16X, 01 is 8X, 10 is 4X and 11 is 16X. A bit tick coincides with sampling tick number N-1, 2N-1, ... after a restart, where N is 16, 8 or 4.
- R7: A load strobe copies all three byte inputs on that clock edge. Both ticks are low in the following cycle, and the first sampling tick comes exactly (prescale·D) clocks after the load edge. Changes on the byte inputs without a strobe have no effect.
- R8: Both ticks are registered single-cycle pulses. A bit tick never occurs without a sampling tick.
- R9: A synchronous active-high reset forces both ticks low and restores the divisor 1, fraction 0 and 16X mode. The bytes last loaded before the reset are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_i | input | 1 | Load strobe for the three divisor bytes; restarts the divider |
| div_lo_i | input | 8 | Integer divisor, low byte |
| div_hi_i | input | 8 | Integer divisor, high byte |
| div_fm_i | input | 6 | [3:0] fraction in sixteenths, [5:4] oversampling mode |
| pre_sel_i | input | 1 | 1 = divide reference by 4 before the divider, 0 = by 1 |
| samp_tick_o | output | 1 | One-cycle sampling-rate tick |
| bit_tick_o | output | 1 | One-cycle tick once per bit time |

## Verification
The assertions check on every cycle that a bit tick never occurs without a sampling tick, and that both ticks are quiet right after a load. They also check that the divider count and the bit count stay within the loaded limits, that the phase accumulator advances by the fraction on each sampling tick, and that ticks are never back to back with the prescaler on. The exact spacing of every sampling tick shows only in the bench scenarios. Those scenarios cover the stretch pattern for each fraction, the prescaler factor, the bit-tick alignment in each mode, the zero divisor and the reset defaults. The bench compares each tick's cycle number with a time it computes arithmetically.

// File: rtl/baud_pkg.sv
package baud_pkg;

  typedef enum logic [1:0] {
    OVS_X16   = 2'b00,
    OVS_X8    = 2'b01,
    OVS_X4    = 2'b10,
    OVS_X16_B = 2'b11
  } ovs_mode_e;

  // index of the last sampling tick in one bit time
  function automatic logic [3:0] ovs_last(ovs_mode_e m);
    case (m)
      OVS_X8:  return 4'd7;
      OVS_X4:  return 4'd3;
      default: return 4'd15;
    endcase
  endfunction

endpackage

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int PRE_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic sel,
  output logic pre_en
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (cnt == PW'(PRE_DIV - 1)) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign pre_en = !sel || (cnt == PW'(PRE_DIV - 1));

  // R5: with divide-by-4 selected, enables are never adjacent
  a_r5_pre_spaced: assert property (@(posedge clk) disable iff (rst)
    (sel && $past(sel) && !$past(restart) && pre_en) |-> !$past(pre_en));

endmodule

// File: rtl/baud_frac_div.sv
module baud_frac_div #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              pre_en,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              hit
);
  logic [INT_W-1:0]  cnt;
  logic [FRAC_W-1:0] acc;
  logic [INT_W-1:0]  int_eff;
  logic [FRAC_W:0]   acc_sum;
  logic              stretch;
  logic [INT_W-1:0]  last;

  always_comb begin
    int_eff = (div_int == '0) ? INT_W'(1) : div_int;
    acc_sum = {1'b0, acc} + {1'b0, div_frac};
    stretch = acc_sum[FRAC_W];
    last    = int_eff - INT_W'(1) + INT_W'(stretch);
  end

  assign hit = pre_en && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
      acc <= '0;
    end else if (pre_en) begin
      if (cnt == last) begin
        cnt <= '0;
        acc <= acc_sum[FRAC_W-1:0];
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R4: the count never passes the stretched period length
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= int_eff);

  // R4: the phase advances by the fraction once per sampling period
  a_r4_acc_step: assert property (@(posedge clk) disable iff (rst)
    (hit && !restart) |=> (acc == FRAC_W'($past(acc) + $past(div_frac))));

endmodule

// File: rtl/baud_bit_count.sv
module baud_bit_count
  import baud_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      restart,
  input  ovs_mode_e mode,
  input  logic      hit,
  output logic      bit_hit
);
  logic [3:0] cnt;
  logic [3:0] lim;

  assign lim     = ovs_last(mode);
  assign bit_hit = hit && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (hit) cnt <= bit_hit ? 4'd0 : cnt + 4'd1;
  end

  // R6: samples-per-bit count stays inside the selected mode
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= lim);

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import baud_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int FRAC_W  = 4,
  parameter int PRE_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_i,
  input  logic [BYTE_W-1:0] div_lo_i,
  input  logic [BYTE_W-1:0] div_hi_i,
  input  logic [FRAC_W+1:0] div_fm_i,
  input  logic              pre_sel_i,
  output logic              samp_tick_o,
  output logic              bit_tick_o
);
  localparam int INT_W = 2 * BYTE_W;
  localparam int FM_W  = FRAC_W + 2;

  logic [BYTE_W-1:0] lo_q, hi_q;
  logic [FM_W-1:0]   fm_q;
  logic              pre_en, hit, bit_hit;
  ovs_mode_e         mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= BYTE_W'(1);
      hi_q <= '0;
      fm_q <= '0;
    end else if (cfg_wr_i) begin
      lo_q <= div_lo_i;
      hi_q <= div_hi_i;
      fm_q <= div_fm_i;
    end
  end

  assign mode = ovs_mode_e'(fm_q[FM_W-1:FRAC_W]);

  baud_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst(rst), .restart(cfg_wr_i),
    .sel(pre_sel_i), .pre_en(pre_en)
  );

  baud_frac_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
    .clk(clk), .rst(rst), .restart(cfg_wr_i), .pre_en(pre_en),
    .div_int({hi_q, lo_q}), .div_frac(fm_q[FRAC_W-1:0]), .hit(hit)
  );

  baud_bit_count u_bit (
    .clk(clk), .rst(rst), .restart(cfg_wr_i),
    .mode(mode), .hit(hit), .bit_hit(bit_hit)
  );

  always_ff @(posedge clk) begin
    if (rst || cfg_wr_i) begin
      samp_tick_o <= 1'b0;
      bit_tick_o  <= 1'b0;
    end else begin
      samp_tick_o <= hit;
      bit_tick_o  <= bit_hit;
    end
  end

  // R8: a bit tick always rides on a sampling tick
  a_r8_bit_on_samp: assert property (@(posedge clk) disable iff (rst)
    bit_tick_o |-> samp_tick_o);

  // R7: both ticks are quiet in the cycle after a load
  a_r7_quiet_after_load: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_wr_i) |-> (!samp_tick_o && !bit_tick_o));

  // R5: prescaled ticks are never back to back
  a_r5_no_adjacent: assert property (@(posedge clk) disable iff (rst)
    (pre_sel_i && $past(pre_sel_i) && samp_tick_o) |-> !$past(samp_tick_o));

endmodule

// File: tb/test_frac_baud_gen.sv
module test_frac_baud_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [7:0] lo = 8'h00, hi = 8'h00;
  logic [5:0] fm = 6'h00;
  logic       psel = 1'b0;
  logic       samp_tick, bit_tick;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  frac_baud_gen i_frac_baud_gen (
    .clk(clk), .rst(rst), .cfg_wr_i(cfg_wr),
    .div_lo_i(lo), .div_hi_i(hi), .div_fm_i(fm), .pre_sel_i(psel),
    .samp_tick_o(samp_tick), .bit_tick_o(bit_tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // drive a load strobe; returns right after the load edge
  task automatic load(input int d, input int h, input int f, input int m, input int s);
    @(negedge clk);
    lo = 8'(d); hi = 8'(h); fm = {2'(m), 4'(f)}; psel = s[0];
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk(!samp_tick && !bit_tick, "R7 quiet after load", int'(samp_tick) + int'(bit_tick), 0);
  endtask

  // follow nt sampling ticks counted from the last restart edge
  task automatic measure(input int dval, input int f, input int m, input int s,
                         input int nt, input string tag);
    int pre, deff, n, t, k, acc, exp;
    pre  = s ? 4 : 1;
    deff = (dval == 0) ? 1 : dval;
    n    = (m == 1) ? 8 : (m == 2) ? 4 : 16;
    t = 0; k = 0; acc = 0;
    exp = pre * (deff + (((acc + f) >= 16) ? 1 : 0));
    while (k < nt) begin
      @(negedge clk);
      t++;
      if (samp_tick) begin
        chk(t == exp, tag, t, exp);
        chk(bit_tick == ((k % n) == n - 1), "R6 bit tick alignment", int'(bit_tick), k);
        acc = (acc + f) % 16;
        k++;
        exp += pre * (deff + (((acc + f) >= 16) ? 1 : 0));
      end else begin
        if (bit_tick) chk(1'b0, "R8 bit tick without sampling tick", 1, 0);
        if (t > exp) begin
          chk(1'b0, tag, t, exp);
          break;
        end
      end
    end
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 190000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R9: reset holds ticks low; byte inputs without a strobe are ignored (R7)
    lo = 8'h07; hi = 8'h02; fm = 6'h2F;
    repeat (3) begin
      @(negedge clk);
      chk(!samp_tick && !bit_tick, "R9 ticks low in reset", int'(samp_tick), 0);
    end
    rst = 1'b0;
    measure(1, 0, 0, 0, 32, "R1 default divisor of one");

    // sweep small divisors over every fraction, mode and prescale
    for (int d = 1; d <= 3; d++)
      for (int f = 0; f < 16; f++)
        for (int m = 0; m < 4; m++)
          for (int s = 0; s < 2; s++) begin
            load(d, 0, f, m, s);
            measure(d, f, m, s, 16, s ? "R5 prescaled period" : (f != 0 ? "R4 fractional period" : "R2 integer period"));
          end

    // R3: zero divisor acts as one
    for (int f = 0; f < 16; f += 5) begin
      load(0, 0, f, 2, 0);
      measure(0, f, 2, 0, 16, "R3 zero divisor");
    end

    // R2: high byte participates
    load(2, 1, 0, 1, 0);
    measure(258, 0, 1, 0, 8, "R2 high byte divisor");
    load(0, 1, 9, 0, 0);
    measure(256, 9, 0, 0, 4, "R4 large divisor with fraction");

    // R9: reset mid-run restores defaults
    load(3, 0, 7, 1, 1);
    measure(3, 7, 1, 1, 5, "R5 before reset");
    @(negedge clk); rst = 1'b1; psel = 1'b0;
    @(negedge clk);
    chk(!samp_tick && !bit_tick, "R9 ticks low in reset", int'(samp_tick), 0);
    rst = 1'b0;
    measure(1, 0, 0, 0, 20, "R9 defaults after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule